// File: doc/BRIEF.md
# Virtual Interrupt Interface Control Register Block

This block holds the control word of a virtual interrupt CPU interface and the two binary point registers that go with it. Software reaches it through a single-cycle request port. Each request carries a read/write flag, a secure/non-secure attribute, a 3-bit register selector and 32 bits of write data. Every accepted request gets a response one cycle later, with read data for reads and zero for writes.

Most of the control word is fixed at elaboration from parameters: extended ID range, range selector support, affinity-3 valid, local error-interrupt support, the ID-width code and the priority-bit field. Two bits can be written.

- **EOI mode** decides whether an end-of-interrupt write both drops priority and deactivates, or drops priority only, leaving deactivation to a separate deactivate register.
- **Common binary point** makes group-1 binary point accesses act on the group-0 register. A non-secure read returns the group-0 value plus one, saturated at 7. A non-secure write is ignored. A secure read returns the group-0 value, and a secure write updates it.

End-of-interrupt and deactivate writes become single-cycle command pulses carrying the written interrupt ID.

A two-state access machine produces the response:
- ST_IDLE moves to ST_RESP on an accepted request (transition T_ACCEPT).
- ST_RESP stays in ST_RESP on a back-to-back request (T_CHAIN).
- ST_RESP returns to ST_IDLE when no request is present (T_DRAIN).

Selector codes are 0 control, 1 group-0 binary point, 2 group-1 binary point, 3 group-0 EOI, 4 group-1 EOI, 5 deactivate, and 6 and 7 unmapped.

Top module: `vctl_regs`

## Requirements
- R1: After reset, with default parameters, the control word reads 0x00080C00 (EOI mode 0, common binary point 0). The group-0 binary point reads 2, the group-1 binary point reads 3, and no response or command pulse is active.
- R2: Control bits 31:20, 17:16 and 7:2 always read zero. A control write changes only bit 1 (EOI mode) and bit 0 (common binary point).
- R3: Bit 19 reads EXT_RANGE, bit 18 RANGE_SEL, bit 15 AFF3_VALID and bit 14 LOCAL_SEI. Bits 13:11 read 000 for 16-bit IDs and 001 for 24-bit IDs. Bits 10:8 read PRIO_BITS-1, which is 4 for the default of 5.
- R4: A request present on a clock edge gives rsp_valid high for exactly the following cycle. rsp_rdata carries the read value for reads and zero for writes. rsp_valid is never high without a request on the previous edge.
- R5: With common binary point 0, selector 1 and selector 2 each read and write their own 3-bit register (data bits 2:0), and the upper read bits are zero.
- R6: With common binary point 1, a non-secure read of selector 2 returns the group-0 value plus one, saturated at 7.
- R7: With common binary point 1, a non-secure write to selector 2 changes neither register.
- R8: With common binary point 1, a secure read of selector 2 returns the group-0 value, and a secure write to selector 2 updates the group-0 register.
- R9: With EOI mode 0, a write to selector 3 or 4 pulses prio_drop_o and deactivate_o together in the next cycle. cmd_id_o carries write data bits 23:0, and cmd_grp1_o is 1 for selector 4.
- R10: With EOI mode 1, an EOI write pulses prio_drop_o only. A write to selector 5 pulses deactivate_o with the ID.
- R11: With EOI mode 0, a write to selector 5 pulses deact_err_o and produces no deactivate_o. deact_err_o and deactivate_o are never high together.
- R12: Command pulses last one cycle per write and appear only after a write to selector 3, 4 or 5.
- R13: Selectors 6 and 7, and reads of selectors 3 to 5, return zero. Writes to selectors 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_secure | input | 1 | 1 secure access, 0 non-secure |
| req_sel | input | 3 | Register selector |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes |
| prio_drop_o | output | 1 | Priority drop command pulse |
| deactivate_o | output | 1 | Deactivate command pulse |
| deact_err_o | output | 1 | Deactivate write while EOI mode is 0 |
| cmd_grp1_o | output | 1 | Command came from the group-1 EOI register |
| cmd_id_o | output | ID_BITS | Interrupt ID of the command |

## Verification
The checker watches the response timing on every cycle. It also checks that every control read shows zero reserved bits and the parameter fields. It checks that command pulses appear only after an EOI or deactivate write, and that the error and deactivate pulses never coincide.

The state-dependent views of the registers can only be shown by the bench's ordered scenarios, because the mode bits are not visible at the ports. Those views are the saturating non-secure alias, the ignored non-secure write, the secure redirect to group 0 and the EOI-mode split.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_BP0   = 3'd1,
        SEL_BP1   = 3'd2,
        SEL_EOI0  = 3'd3,
        SEL_EOI1  = 3'd4,
        SEL_DEACT = 3'd5,
        SEL_RSV6  = 3'd6,
        SEL_RSV7  = 3'd7
    } vctl_sel_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } vctl_state_e;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BP_W      = 3;
    localparam int unsigned POS_EXT   = 19;
    localparam int unsigned POS_RSEL  = 18;
    localparam int unsigned POS_AFF3  = 15;
    localparam int unsigned POS_SEI   = 14;
    localparam int unsigned POS_IDLO  = 11;
    localparam int unsigned POS_PRILO = 8;
    localparam int unsigned POS_EOIM  = 1;
    localparam int unsigned POS_CBP   = 0;

    function automatic logic [2:0] id_width_code(input int unsigned bits);
        return (bits == 24) ? 3'b001 : 3'b000;
    endfunction

    function automatic logic [BP_W-1:0] bp_plus_one_sat(input logic [BP_W-1:0] v);
        return (v == {BP_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/vctl_cfg_word.sv
module vctl_cfg_word
    import vctl_pkg::*;
#(
    parameter bit          EXT_RANGE  = 1'b1,
    parameter bit          RANGE_SEL  = 1'b0,
    parameter bit          AFF3_VALID = 1'b0,
    parameter bit          LOCAL_SEI  = 1'b0,
    parameter int unsigned ID_BITS    = 24,
    parameter int unsigned PRIO_BITS  = 5
) (
    output logic [WORD_W-1:0] ro_word
);
    localparam logic [2:0] ID_CODE  = id_width_code(ID_BITS);
    localparam int unsigned PRI_EFF = (PRIO_BITS < 5) ? 5 : PRIO_BITS;
    localparam logic [2:0] PRI_CODE = 3'(PRI_EFF - 1);

    always_comb begin
        ro_word = '0;
        ro_word[POS_EXT]  = EXT_RANGE;
        ro_word[POS_RSEL] = RANGE_SEL;
        ro_word[POS_AFF3] = AFF3_VALID;
        ro_word[POS_SEI]  = LOCAL_SEI;
        ro_word[POS_IDLO +: 3]  = ID_CODE;
        ro_word[POS_PRILO +: 3] = PRI_CODE;
    end
endmodule

// File: rtl/vctl_bp_bank.sv
module vctl_bp_bank
    import vctl_pkg::*;
#(
    parameter logic [BP_W-1:0] BP0_RST = 3'd2,
    parameter logic [BP_W-1:0] BP1_RST = 3'd3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_bp0,
    input  logic            wr_bp1,
    input  logic            secure,
    input  logic            cbpr,
    input  logic [BP_W-1:0] wval,
    output logic [BP_W-1:0] bp0_view,
    output logic [BP_W-1:0] bp1_view
);
    logic [BP_W-1:0] bp0_q, bp1_q;
    logic            bp0_we, bp1_we;

    always_comb begin
        bp0_we = wr_bp0 || (wr_bp1 && cbpr && secure);
        bp1_we = wr_bp1 && !cbpr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp0_q <= BP0_RST;
            bp1_q <= BP1_RST;
        end else begin
            if (bp0_we) bp0_q <= wval;
            if (bp1_we) bp1_q <= wval;
        end
    end

    always_comb begin
        bp0_view = bp0_q;
        if (!cbpr)       bp1_view = bp1_q;
        else if (secure) bp1_view = bp0_q;
        else             bp1_view = bp_plus_one_sat(bp0_q);
    end
endmodule

// File: rtl/vctl_cmd_decode.sv
module vctl_cmd_decode #(
    parameter int unsigned ID_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_eoi0,
    input  logic            wr_eoi1,
    input  logic            wr_deact,
    input  logic            eoi_mode,
    input  logic [ID_W-1:0] id_in,
    output logic            drop_o,
    output logic            deact_o,
    output logic            err_o,
    output logic            grp1_o,
    output logic [ID_W-1:0] id_o
);
    logic drop_d, deact_d, err_d, any_cmd;

    always_comb begin
        drop_d  = wr_eoi0 || wr_eoi1;
        deact_d = (drop_d && !eoi_mode) || (wr_deact && eoi_mode);
        err_d   = wr_deact && !eoi_mode;
        any_cmd = drop_d || wr_deact;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_o  <= 1'b0;
            deact_o <= 1'b0;
            err_o   <= 1'b0;
            grp1_o  <= 1'b0;
            id_o    <= '0;
        end else begin
            drop_o  <= drop_d;
            deact_o <= deact_d;
            err_o   <= err_d;
            if (any_cmd) begin
                grp1_o <= wr_eoi1;
                id_o   <= id_in;
            end
        end
    end
endmodule

// File: rtl/vctl_regs.sv
module vctl_regs
    import vctl_pkg::*;
#(
    parameter bit          EXT_RANGE  = 1'b1,
    parameter bit          RANGE_SEL  = 1'b0,
    parameter bit          AFF3_VALID = 1'b0,
    parameter bit          LOCAL_SEI  = 1'b0,
    parameter int unsigned ID_BITS    = 24,
    parameter int unsigned PRIO_BITS  = 5,
    parameter logic [2:0]  BP0_RST    = 3'd2,
    parameter logic [2:0]  BP1_RST    = 3'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_secure,
    input  logic [2:0]         req_sel,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               prio_drop_o,
    output logic               deactivate_o,
    output logic               deact_err_o,
    output logic               cmd_grp1_o,
    output logic [ID_BITS-1:0] cmd_id_o
);
    localparam int unsigned ID_W = ID_BITS;

    vctl_state_e     state_q, state_d;
    vctl_sel_e       sel;
    logic            eoi_mode_q, cbpr_q;
    logic [31:0]     ro_word, rd_mux;
    logic [BP_W-1:0] bp0_view, bp1_view;
    logic            wr_any, wr_ctrl;
    logic            unused_wdata_hi;

    assign sel             = vctl_sel_e'(req_sel);
    assign wr_any          = req_valid && req_write;
    assign wr_ctrl         = wr_any && (sel == SEL_CTRL);
    assign unused_wdata_hi = ^req_wdata[31:ID_W];

    vctl_cfg_word #(
        .EXT_RANGE (EXT_RANGE),
        .RANGE_SEL (RANGE_SEL),
        .AFF3_VALID(AFF3_VALID),
        .LOCAL_SEI (LOCAL_SEI),
        .ID_BITS   (ID_BITS),
        .PRIO_BITS (PRIO_BITS)
    ) cfg_i (
        .ro_word(ro_word)
    );

    vctl_bp_bank #(
        .BP0_RST(BP0_RST),
        .BP1_RST(BP1_RST)
    ) bp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_bp0  (wr_any && (sel == SEL_BP0)),
        .wr_bp1  (wr_any && (sel == SEL_BP1)),
        .secure  (req_secure),
        .cbpr    (cbpr_q),
        .wval    (req_wdata[BP_W-1:0]),
        .bp0_view(bp0_view),
        .bp1_view(bp1_view)
    );

    vctl_cmd_decode #(
        .ID_W(ID_W)
    ) cmd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_eoi0 (wr_any && (sel == SEL_EOI0)),
        .wr_eoi1 (wr_any && (sel == SEL_EOI1)),
        .wr_deact(wr_any && (sel == SEL_DEACT)),
        .eoi_mode(eoi_mode_q),
        .id_in   (req_wdata[ID_W-1:0]),
        .drop_o  (prio_drop_o),
        .deact_o (deactivate_o),
        .err_o   (deact_err_o),
        .grp1_o  (cmd_grp1_o),
        .id_o    (cmd_id_o)
    );

    // Writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_mode_q <= 1'b0;
            cbpr_q     <= 1'b0;
        end else if (wr_ctrl) begin
            eoi_mode_q <= req_wdata[POS_EOIM];
            cbpr_q     <= req_wdata[POS_CBP];
        end
    end

    // Read selection
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CTRL: begin
                rd_mux = ro_word;
                rd_mux[POS_EOIM] = eoi_mode_q;
                rd_mux[POS_CBP]  = cbpr_q;
            end
            SEL_BP0: rd_mux[BP_W-1:0] = bp0_view;
            SEL_BP1: rd_mux[BP_W-1:0] = bp1_view;
            SEL_EOI0, SEL_EOI1, SEL_DEACT, SEL_RSV6, SEL_RSV7: rd_mux = '0;
        endcase
    end

    // Access machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Access machine: next state (T_ACCEPT, T_CHAIN, T_DRAIN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
        endcase
    end

    // Access machine: outputs
    assign rsp_valid = (state_q == ST_RESP);

    always_ff @(posedge clk) begin
        if (!rst_n)         rsp_rdata <= '0;
        else if (req_valid) rsp_rdata <= req_write ? 32'd0 : rd_mux;
        else                rsp_rdata <= '0;
    end
endmodule

// File: rtl/vctl_regs_chk.sv
module vctl_regs_chk #(
    parameter bit          EXT_RANGE  = 1'b1,
    parameter bit          RANGE_SEL  = 1'b0,
    parameter bit          AFF3_VALID = 1'b0,
    parameter bit          LOCAL_SEI  = 1'b0,
    parameter int unsigned ID_BITS    = 24,
    parameter int unsigned PRIO_BITS  = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [2:0]  req_sel,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        prio_drop_o,
    input logic        deactivate_o,
    input logic        deact_err_o
);
    localparam logic [2:0] ID_CODE  = (ID_BITS == 24) ? 3'b001 : 3'b000;
    localparam logic [2:0] PRI_CODE = 3'(((PRIO_BITS < 5) ? 5 : PRIO_BITS) - 1);

    logic rd_ctrl, wr_eoi, wr_cmd;
    assign rd_ctrl = req_valid && !req_write && (req_sel == 3'd0);
    assign wr_eoi  = req_valid && req_write && (req_sel == 3'd3 || req_sel == 3'd4);
    assign wr_cmd  = wr_eoi || (req_valid && req_write && req_sel == 3'd5);

    // R4
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R2
    ctrl_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rd_ctrl)) |->
            (rsp_rdata[31:20] == 12'd0 && rsp_rdata[17:16] == 2'd0 && rsp_rdata[7:2] == 6'd0));

    // R3
    ctrl_cfg_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rd_ctrl)) |->
            (rsp_rdata[19] == EXT_RANGE && rsp_rdata[18] == RANGE_SEL &&
             rsp_rdata[15] == AFF3_VALID && rsp_rdata[14] == LOCAL_SEI &&
             rsp_rdata[13:11] == ID_CODE && rsp_rdata[10:8] == PRI_CODE));

    // R11
    deact_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deact_err_o |-> !deactivate_o);

    // R9
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prio_drop_o |-> $past(wr_eoi));

    // R12
    cmd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deactivate_o || deact_err_o) |-> $past(wr_cmd));
endmodule

bind vctl_regs vctl_regs_chk #(
    .EXT_RANGE (EXT_RANGE),
    .RANGE_SEL (RANGE_SEL),
    .AFF3_VALID(AFF3_VALID),
    .LOCAL_SEI (LOCAL_SEI),
    .ID_BITS   (ID_BITS),
    .PRIO_BITS (PRIO_BITS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_sel     (req_sel),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .prio_drop_o (prio_drop_o),
    .deactivate_o(deactivate_o),
    .deact_err_o (deact_err_o)
);

// File: tb/vctl_regs_tb.sv
module vctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_secure;
    logic [2:0]  req_sel;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        prio_drop_o, deactivate_o, deact_err_o, cmd_grp1_o;
    logic [23:0] cmd_id_o;

    int tests_run = 0;
    int tests_failed = 0;

    always #4 clk = ~clk;

    vctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_sel(req_sel), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .prio_drop_o(prio_drop_o),
        .deactivate_o(deactivate_o), .deact_err_o(deact_err_o),
        .cmd_grp1_o(cmd_grp1_o), .cmd_id_o(cmd_id_o)
    );

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [2:0]  sel;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] rd;
        logic        drop;
        logic        deact;
        logic        err;
        logic        grp1;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,3'd0,32'h0,        1'b1,32'h00080C00,1'b0,1'b0,1'b0,1'b0,8'd1},  // R1 R3
        '{1'b0,1'b0,3'd1,32'h0,        1'b1,32'h2,       1'b0,1'b0,1'b0,1'b0,8'd1},  // R1
        '{1'b0,1'b0,3'd2,32'h0,        1'b1,32'h3,       1'b0,1'b0,1'b0,1'b0,8'd1},  // R1
        '{1'b1,1'b0,3'd0,32'hFFFFFFFF, 1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd4},  // R4
        '{1'b0,1'b0,3'd0,32'h0,        1'b1,32'h00080C03,1'b0,1'b0,1'b0,1'b0,8'd2},  // R2
        '{1'b1,1'b0,3'd0,32'hFFFFFFFC, 1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd2},  // R2
        '{1'b0,1'b0,3'd0,32'h0,        1'b1,32'h00080C00,1'b0,1'b0,1'b0,1'b0,8'd2},  // R2
        '{1'b1,1'b0,3'd1,32'hFFFFFFF5, 1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{1'b1,1'b0,3'd2,32'h00000001, 1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{1'b0,1'b0,3'd1,32'h0,        1'b1,32'h5,       1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{1'b0,1'b0,3'd2,32'h0,        1'b1,32'h1,       1'b0,1'b0,1'b0,1'b0,8'd5},  // R5
        '{1'b1,1'b0,3'd0,32'h1,        1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd6},  // R6 set cbp
        '{1'b0,1'b0,3'd2,32'h0,        1'b1,32'h6,       1'b0,1'b0,1'b0,1'b0,8'd6},  // R6
        '{1'b1,1'b0,3'd1,32'h7,        1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd6},  // R6
        '{1'b0,1'b0,3'd2,32'h0,        1'b1,32'h7,       1'b0,1'b0,1'b0,1'b0,8'd6},  // R6 saturation
        '{1'b1,1'b0,3'd2,32'h2,        1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd7},  // R7
        '{1'b0,1'b0,3'd1,32'h0,        1'b1,32'h7,       1'b0,1'b0,1'b0,1'b0,8'd7},  // R7
        '{1'b0,1'b1,3'd2,32'h0,        1'b1,32'h7,       1'b0,1'b0,1'b0,1'b0,8'd8},  // R8
        '{1'b1,1'b1,3'd2,32'h4,        1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd8},  // R8
        '{1'b0,1'b0,3'd1,32'h0,        1'b1,32'h4,       1'b0,1'b0,1'b0,1'b0,8'd8},  // R8
        '{1'b0,1'b1,3'd2,32'h0,        1'b1,32'h4,       1'b0,1'b0,1'b0,1'b0,8'd8},  // R8
        '{1'b1,1'b0,3'd0,32'h0,        1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd7},  // R7 clear cbp
        '{1'b0,1'b0,3'd2,32'h0,        1'b1,32'h1,       1'b0,1'b0,1'b0,1'b0,8'd7},  // R7 own reg kept
        '{1'b1,1'b0,3'd3,32'hAB000123, 1'b1,32'h0,       1'b1,1'b1,1'b0,1'b0,8'd9},  // R9
        '{1'b1,1'b0,3'd5,32'h00000055, 1'b1,32'h0,       1'b0,1'b0,1'b1,1'b0,8'd11}, // R11
        '{1'b1,1'b0,3'd0,32'h2,        1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd10}, // R10 set eoi mode
        '{1'b1,1'b0,3'd4,32'h00000077, 1'b1,32'h0,       1'b1,1'b0,1'b0,1'b1,8'd10}, // R10
        '{1'b1,1'b0,3'd5,32'h00000078, 1'b1,32'h0,       1'b0,1'b1,1'b0,1'b0,8'd10}, // R10
        '{1'b0,1'b0,3'd6,32'h0,        1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd13}, // R13
        '{1'b1,1'b0,3'd7,32'hFFFFFFFF, 1'b1,32'h0,       1'b0,1'b0,1'b0,1'b0,8'd13}  // R13
    };

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
        end
    endtask

    // Drive one request before an edge, sample the registered result after it.
    task automatic access(input logic wr, input logic sec, input logic [2:0] sel,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_secure = sec; req_sel = sel; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0; req_sel = 3'd0; req_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
        req_sel = 3'd0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check(!rsp_valid && !prio_drop_o && !deactivate_o && !deact_err_o, 1,
              "reset outputs idle", {28'd0, rsp_valid, prio_drop_o, deactivate_o, deact_err_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].sec, VECS[i].sel, VECS[i].wd);
            check(rsp_valid == 1'b1, 4, "response valid", {31'd0, rsp_valid}, 32'd1);
            check(rsp_rdata == VECS[i].rd, VECS[i].rq, "read data", rsp_rdata, VECS[i].rd);
            check({prio_drop_o, deactivate_o, deact_err_o} == {VECS[i].drop, VECS[i].deact, VECS[i].err},
                  VECS[i].rq, "command pulses",
                  {29'd0, prio_drop_o, deactivate_o, deact_err_o},
                  {29'd0, VECS[i].drop, VECS[i].deact, VECS[i].err});
            if (VECS[i].drop || VECS[i].deact) begin
                check(cmd_id_o == VECS[i].wd[23:0], VECS[i].rq, "command id",
                      {8'd0, cmd_id_o}, {8'd0, VECS[i].wd[23:0]});
                check(cmd_grp1_o == VECS[i].grp1, VECS[i].rq, "command group",
                      {31'd0, cmd_grp1_o}, {31'd0, VECS[i].grp1});
            end
            // R12 and R4: one cycle later everything has dropped
            @(negedge clk);
            check(!rsp_valid && !prio_drop_o && !deactivate_o && !deact_err_o, 12,
                  "single-cycle outputs", {28'd0, rsp_valid, prio_drop_o, deactivate_o, deact_err_o}, 32'd0);
        end

        // R13: the write to selector 7 left the control word at 0x00080C02
        access(1'b0, 1'b0, 3'd0, 32'h0);
        check(rsp_rdata == 32'h00080C02, 13, "unmapped write no effect", rsp_rdata, 32'h00080C02);

        // R12: back-to-back EOI writes give one pulse per write (EOI mode 1)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = 3'd3; req_wdata = 32'h11;
        @(negedge clk);
        req_wdata = 32'h22;
        check(prio_drop_o && !deactivate_o && cmd_id_o == 24'h11, 12, "first of pair",
              {8'd0, cmd_id_o}, 32'h11);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
        check(prio_drop_o && rsp_valid && cmd_id_o == 24'h22, 12, "second of pair",
              {8'd0, cmd_id_o}, 32'h22);
        @(negedge clk);
        check(!prio_drop_o && !rsp_valid, 12, "pair ends", {31'd0, prio_drop_o}, 32'd0);

        // R1: reset in mid-run restores defaults
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 1'b0, 3'd0, 32'h0);
        check(rsp_rdata == 32'h00080C00, 1, "ctrl after re-reset", rsp_rdata, 32'h00080C00);
        access(1'b0, 1'b0, 3'd1, 32'h0);
        check(rsp_rdata == 32'h2, 1, "bp0 after re-reset", rsp_rdata, 32'h2);
        access(1'b0, 1'b0, 3'd2, 32'h0);
        check(rsp_rdata == 32'h3, 1, "bp1 after re-reset", rsp_rdata, 32'h3);

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule